// File: doc/BRIEF.md
# Split Condition-Flag Status Register

This block holds a processor's 32-bit status word as five separate pieces of storage. The arithmetic flags are kept in four of them: a 2-bit sign/zero piece, a 1-bit carry piece, a 1-bit overflow piece and a 4-bit per-byte greater-or-equal piece. The fifth is a register for all the remaining status bits. Each flag piece has its own write enable. An instruction that produces only some of the flags therefore writes only those pieces and does not have to wait for the producers of the others.

Several update sources share the flag pieces. The first is a direct write port for each piece. The second is a logical-class update, which writes sign/zero and, when a shift took place, carry. The third is a floating-point compare transfer, which loads sign, zero, carry and overflow from the top nibble of the FP status word. The fourth is a full-word write under a byte mask. The full-word write first merges the new word into the current composed word, then splits the result back into all five pieces.

On the read side, the block merges the pieces into the composed word. It also provides a masked copy of that word for status-read instructions, and the next IT execution state decoded from the word. All writes are registered and take effect at the next clock edge.

Top module: `sfr_flag_status`

## Requirements
- R1: A synchronous active-high reset clears every flag piece and the remaining-status register, so the composed word reads 0 in the cycle after reset. Reset wins over any write in the same cycle.
- R2: The composed word places N at bit 31, Z at bit 30, C at bit 29, V at bit 28 and GE at bits 19:16. The sign/zero piece holds N in its bit 1 and Z in its bit 0. All other bits come from the remaining-status register, which stores the written word ANDed with ~0xF00F0000.
- R3: The status-read output equals the composed word ANDed with 0xF8FF03DF.
- R4: Each piece write (sign/zero, carry, overflow, GE) has its own enable. Writes to different pieces in the same cycle all take effect at the next edge. Pieces that are not written keep their values; for example, a sign/zero write leaves C and V unchanged.
- R5: A logical-class update writes the sign/zero piece. It loads C from the shifter carry-out when its shift indicator is 1 and keeps the old C when it is 0. V is never changed by this update.
- R6: A floating-point compare transfer loads N, Z, C and V from FP status bits 31, 30, 29 and 28 (input bits 3, 2, 1, 0). GE is left unchanged.
- R7: A full-word write replaces byte i (bits 8i+7:8i) of the current composed word with the new data where byte-mask bit i is 1, and keeps it where the bit is 0. The result is split into the four flag pieces and the remaining-status register.
- R8: Priority per piece, highest first: full-word write, FP transfer, logical-class update, then the direct piece write.
- R9: The next IT state output is ((it2 << 2) & 0xFC) | (it1 & 0x3), where it2 is composed-word bits 15:10 and it1 is bits 26:25.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nz_we | input | 1 | Direct write enable, sign/zero piece |
| nz_wdata | input | 2 | Sign/zero data, N in bit 1, Z in bit 0 |
| c_we | input | 1 | Direct write enable, carry piece |
| c_wdata | input | 1 | Carry data |
| v_we | input | 1 | Direct write enable, overflow piece |
| v_wdata | input | 1 | Overflow data |
| ge_we | input | 1 | Direct write enable, GE piece |
| ge_wdata | input | 4 | GE data |
| lg_we | input | 1 | Logical-class flag update |
| lg_nz | input | 2 | Sign/zero result of the logical operation |
| lg_shifted | input | 1 | 1 when the shifter produced a carry-out |
| lg_carry | input | 1 | Shifter carry-out |
| fp_we | input | 1 | FP compare transfer |
| fp_flags | input | 4 | FP status bits 31:28 (N, Z, C, V) |
| word_we | input | 1 | Full-word write |
| word_bmask | input | 4 | Byte mask for the full-word write |
| word_wdata | input | 32 | Full-word write data |
| status_word | output | 32 | Composed status word |
| status_read | output | 32 | Masked word for status reads |
| it_next | output | 8 | Next IT state from the composed word |
| nz_q | output | 2 | Sign/zero piece |
| c_q | output | 1 | Carry piece |
| v_q | output | 1 | Overflow piece |
| ge_q | output | 4 | GE piece |

## Verification
Every piece feeds the composed word directly, so a wrongly updated or stale piece shows up on `status_word` in the cycle right after the faulty write. It shows up even on flags the operation was not meant to touch. A bad priority choice or byte-mask merge shows up the same way, one edge after the write. A mis-placed bit in the remaining-status register shows up either as a flag-position bit that should be clear or as a wrong `it_next` value. The sweep drives every combination of the six update enables with varying data, and every byte mask both with and without competing piece writes. After each edge it compares all outputs against a word-level model of the requirements.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
   // Bit positions inside the composed status word that consumers decode.
   localparam int N_POS   = 31;
   localparam int Z_POS   = 30;
   localparam int C_POS   = 29;
   localparam int V_POS   = 28;
   localparam int IT1_LSB = 25;
   localparam int IT1_W   = 2;
   localparam int IT2_LSB = 10;
   localparam int IT2_W   = 6;

   typedef struct packed {
      logic [1:0] nz;
      logic       c;
      logic       v;
   } nzcv_t;
endpackage

// File: rtl/sfr_piece.sv
module sfr_piece #(
   parameter int W = 1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         we,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (rst)     q <= '0;
      else if (we) q <= d;
   end
endmodule

// File: rtl/sfr_byte_merge.sv
module sfr_byte_merge #(
   parameter int WORD_W = 32,
   localparam int NBYTES = WORD_W / 8
) (
   input  logic [WORD_W-1:0] old_word,
   input  logic [WORD_W-1:0] new_word,
   input  logic [NBYTES-1:0] bmask,
   output logic [WORD_W-1:0] merged
);
   for (genvar b = 0; b < NBYTES; b++) begin : g_byte
      assign merged[8*b +: 8] = bmask[b] ? new_word[8*b +: 8] : old_word[8*b +: 8];
   end
endmodule

// File: rtl/sfr_compose.sv
module sfr_compose
   import sfr_pkg::*;
#(
   parameter int              WORD_W    = 32,
   parameter int              GE_LSB    = 16,
   parameter int              GE_W      = 4,
   parameter logic [WORD_W-1:0] READ_MASK = 32'hF8FF03DF
) (
   input  nzcv_t             flags,
   input  logic [GE_W-1:0]   ge,
   input  logic [WORD_W-1:0] rest,
   output logic [WORD_W-1:0] word,
   output logic [WORD_W-1:0] read_word,
   output logic [IT1_W+IT2_W-1:0] it_next
);
   always_comb begin
      word                = rest;
      word[N_POS]         = flags.nz[1];
      word[Z_POS]         = flags.nz[0];
      word[C_POS]         = flags.c;
      word[V_POS]         = flags.v;
      word[GE_LSB +: GE_W] = ge;
   end

   assign read_word = word & READ_MASK;
   assign it_next   = {word[IT2_LSB +: IT2_W], word[IT1_LSB +: IT1_W]};
endmodule

// File: rtl/sfr_flag_status.sv
module sfr_flag_status
   import sfr_pkg::*;
#(
   parameter int                WORD_W    = 32,
   parameter int                GE_LSB    = 16,
   parameter int                GE_W      = 4,
   parameter logic [WORD_W-1:0] FLAG_MASK = 32'hF00F0000,
   parameter logic [WORD_W-1:0] READ_MASK = 32'hF8FF03DF,
   localparam int               NBYTES    = WORD_W / 8,
   localparam int               IT_W      = IT1_W + IT2_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              nz_we,
   input  logic [1:0]        nz_wdata,
   input  logic              c_we,
   input  logic              c_wdata,
   input  logic              v_we,
   input  logic              v_wdata,
   input  logic              ge_we,
   input  logic [GE_W-1:0]   ge_wdata,
   input  logic              lg_we,
   input  logic [1:0]        lg_nz,
   input  logic              lg_shifted,
   input  logic              lg_carry,
   input  logic              fp_we,
   input  logic [3:0]        fp_flags,
   input  logic              word_we,
   input  logic [NBYTES-1:0] word_bmask,
   input  logic [WORD_W-1:0] word_wdata,
   output logic [WORD_W-1:0] status_word,
   output logic [WORD_W-1:0] status_read,
   output logic [IT_W-1:0]   it_next,
   output logic [1:0]        nz_q,
   output logic              c_q,
   output logic              v_q,
   output logic [GE_W-1:0]   ge_q
);
   localparam logic [WORD_W-1:0] DERIVED_MASK =
      (WORD_W'(4'hF) << V_POS) | (WORD_W'((1 << GE_W) - 1) << GE_LSB);

   // Elaboration checks on the configuration
   if (WORD_W != 32) begin : g_bad_width
      $error("sfr_flag_status: WORD_W must be 32");
   end
   if (GE_LSB + GE_W > V_POS) begin : g_bad_ge
      $error("sfr_flag_status: GE field overlaps NZCV");
   end
   if (FLAG_MASK != DERIVED_MASK) begin : g_bad_mask
      $error("sfr_flag_status: FLAG_MASK disagrees with field positions");
   end

   logic [WORD_W-1:0] merged;
   logic [WORD_W-1:0] rest_q, rest_d;
   logic [1:0]        nz_d;
   logic              c_d, v_d;
   logic [GE_W-1:0]   ge_d;
   logic              nz_en, c_en, v_en, ge_en;
   nzcv_t             cur_flags;

   assign cur_flags = '{nz: nz_q, c: c_q, v: v_q};

   sfr_compose #(
      .WORD_W(WORD_W), .GE_LSB(GE_LSB), .GE_W(GE_W), .READ_MASK(READ_MASK)
   ) u_compose (
      .flags(cur_flags), .ge(ge_q), .rest(rest_q),
      .word(status_word), .read_word(status_read), .it_next(it_next)
   );

   sfr_byte_merge #(.WORD_W(WORD_W)) u_merge (
      .old_word(status_word), .new_word(word_wdata),
      .bmask(word_bmask), .merged(merged)
   );

   // Per-piece source selection: word > FP transfer > logical update > direct
   always_comb begin
      nz_en = word_we | fp_we | lg_we | nz_we;
      if (word_we)    nz_d = {merged[N_POS], merged[Z_POS]};
      else if (fp_we) nz_d = fp_flags[3:2];
      else if (lg_we) nz_d = lg_nz;
      else            nz_d = nz_wdata;

      c_en = word_we | fp_we | (lg_we & lg_shifted) | c_we;
      if (word_we)                  c_d = merged[C_POS];
      else if (fp_we)               c_d = fp_flags[1];
      else if (lg_we && lg_shifted) c_d = lg_carry;
      else                          c_d = c_wdata;

      v_en = word_we | fp_we | v_we;
      if (word_we)    v_d = merged[V_POS];
      else if (fp_we) v_d = fp_flags[0];
      else            v_d = v_wdata;

      ge_en = word_we | ge_we;
      ge_d  = word_we ? merged[GE_LSB +: GE_W] : ge_wdata;

      rest_d = merged & ~FLAG_MASK;
   end

   sfr_piece #(.W(2))      u_nz   (.clk(clk), .rst(rst), .we(nz_en),   .d(nz_d),   .q(nz_q));
   sfr_piece #(.W(1))      u_c    (.clk(clk), .rst(rst), .we(c_en),    .d(c_d),    .q(c_q));
   sfr_piece #(.W(1))      u_v    (.clk(clk), .rst(rst), .we(v_en),    .d(v_d),    .q(v_q));
   sfr_piece #(.W(GE_W))   u_ge   (.clk(clk), .rst(rst), .we(ge_en),   .d(ge_d),   .q(ge_q));
   sfr_piece #(.W(WORD_W)) u_rest (.clk(clk), .rst(rst), .we(word_we), .d(rest_d), .q(rest_q));

   // Assertions
   p_reset_clear_r1: assert property (@(posedge clk)
      rst |=> (status_word == '0));

   p_c_hold_r4: assert property (@(posedge clk) disable iff (rst)
      (!word_we && !fp_we && !(lg_we && lg_shifted) && !c_we) |=> $stable(c_q));

   p_v_hold_r5: assert property (@(posedge clk) disable iff (rst)
      (!word_we && !fp_we && !v_we) |=> $stable(v_q));

   p_ge_hold_r6: assert property (@(posedge clk) disable iff (rst)
      (!word_we && !ge_we) |=> $stable(ge_q));

   p_fp_load_r6: assert property (@(posedge clk) disable iff (rst)
      (fp_we && !word_we) |=> ({nz_q, c_q, v_q} == $past(fp_flags)));

   p_full_write_r7: assert property (@(posedge clk) disable iff (rst)
      (word_we && (word_bmask == '1)) |=> (status_word == $past(word_wdata)));

   p_word_first_r8: assert property (@(posedge clk) disable iff (rst)
      (word_we && word_bmask[NBYTES-1] && (fp_we || lg_we || nz_we))
      |=> (nz_q == $past(word_wdata[N_POS:Z_POS])));
endmodule

// File: tb/tb_sfr_flag_status.sv
module tb_sfr_flag_status;
   logic        clk = 1'b0;
   logic        rst;
   logic        nz_we, c_we, v_we, ge_we, lg_we, fp_we, word_we;
   logic [1:0]  nz_wdata, lg_nz;
   logic        c_wdata, v_wdata, lg_shifted, lg_carry;
   logic [3:0]  ge_wdata, fp_flags, word_bmask;
   logic [31:0] word_wdata;
   logic [31:0] status_word, status_read;
   logic [7:0]  it_next;
   logic [1:0]  nz_q;
   logic        c_q, v_q;
   logic [3:0]  ge_q;

   int          n_chk  = 0;
   int          n_fail = 0;
   logic [31:0] exp_w  = '0;
   logic [31:0] rnd    = 32'h1D2C_3B4A;
   bit          done   = 0;

   always #10 clk = ~clk;   // 50 MHz

   sfr_flag_status dut (
      .clk(clk), .rst(rst),
      .nz_we(nz_we), .nz_wdata(nz_wdata), .c_we(c_we), .c_wdata(c_wdata),
      .v_we(v_we), .v_wdata(v_wdata), .ge_we(ge_we), .ge_wdata(ge_wdata),
      .lg_we(lg_we), .lg_nz(lg_nz), .lg_shifted(lg_shifted), .lg_carry(lg_carry),
      .fp_we(fp_we), .fp_flags(fp_flags),
      .word_we(word_we), .word_bmask(word_bmask), .word_wdata(word_wdata),
      .status_word(status_word), .status_read(status_read), .it_next(it_next),
      .nz_q(nz_q), .c_q(c_q), .v_q(v_q), .ge_q(ge_q)
   );

   function automatic logic [31:0] nxt(input logic [31:0] x);
      logic [31:0] y = x;
      y = y ^ (y << 13);
      y = y ^ (y >> 17);
      y = y ^ (y << 5);
      return y;
   endfunction

   // Word-level reference model of one edge (R4..R8)
   function automatic logic [31:0] model(input logic [31:0] cur);
      logic [31:0] r = cur;
      if (word_we) begin
         for (int b = 0; b < 4; b++)
            if (word_bmask[b]) r[8*b +: 8] = word_wdata[8*b +: 8];
         return r;
      end
      if (fp_we) r[31:28] = fp_flags;
      else begin
         if (lg_we) r[31:30] = lg_nz;
         else if (nz_we) r[31:30] = nz_wdata;
         if (lg_we && lg_shifted) r[29] = lg_carry;
         else if (c_we) r[29] = c_wdata;
         if (v_we) r[28] = v_wdata;
      end
      if (ge_we) r[19:16] = ge_wdata;
      return r;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
      n_chk++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s: actual %08h expected %08h", tag, act, expv);
      end
   endtask

   task automatic check_all(input string tag);
      chk(tag, status_word, exp_w);
      chk({tag, " pieces"}, {24'b0, nz_q, c_q, v_q, ge_q}, {24'b0, exp_w[31:28], exp_w[19:16]});
      chk("R3 read mask", status_read, exp_w & 32'hF8FF03DF);
      chk("R9 it_next", {24'b0, it_next}, {24'b0, exp_w[15:10], exp_w[26:25]});
   endtask

   task automatic idle_inputs();
      {nz_we, c_we, v_we, ge_we, lg_we, fp_we, word_we} = '0;
      nz_wdata = '0; c_wdata = 0; v_wdata = 0; ge_wdata = '0;
      lg_nz = '0; lg_shifted = 0; lg_carry = 0; fp_flags = '0;
      word_bmask = '0; word_wdata = '0;
   endtask

   task automatic tick(input string tag);
      logic [31:0] n = rst ? 32'h0 : model(exp_w);
      @(posedge clk);
      exp_w = n;
      @(negedge clk);
      check_all(tag);
      idle_inputs();
   endtask

   task automatic rand_data();
      rnd = nxt(rnd); {nz_wdata, c_wdata, v_wdata, ge_wdata, lg_nz, lg_carry, lg_shifted} = rnd[12:0];
      rnd = nxt(rnd); fp_flags = rnd[3:0];
      rnd = nxt(rnd); word_wdata = rnd;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      idle_inputs();
      rst = 1;
      @(negedge clk);
      // R1: reset clears everything, even with a write pending
      word_we = 1; word_bmask = 4'hF; word_wdata = 32'hFFFF_FFFF;
      tick("R1 reset");
      rst = 0;

      // R2/R7: full-mask word writes, including all-ones to probe the rest register
      word_we = 1; word_bmask = 4'hF; word_wdata = 32'hFFFF_FFFF; tick("R2 all ones");
      word_we = 1; word_bmask = 4'hF; word_wdata = 32'h0200_2400; tick("R9 it pattern");
      word_we = 1; word_bmask = 4'hF; word_wdata = 32'h0FF0_FFFF; tick("R2 rest only");
      nz_we = 1; nz_wdata = 2'b10; tick("R4 nz only keeps C V");
      lg_we = 1; lg_nz = 2'b01; lg_shifted = 0; lg_carry = 1; c_we = 1; c_wdata = 1;
      tick("R5 no shift keeps C");

      // R4/R5/R6/R8: sweep all direct/logic/FP enable combinations
      for (int k = 0; k < 4; k++) begin
         for (int e = 0; e < 64; e++) begin
            rand_data();
            {fp_we, lg_we, ge_we, v_we, c_we, nz_we} = 6'(e);
            if (fp_we)      tick("R6 R8 fp transfer");
            else if (lg_we) tick("R5 R8 logical update");
            else            tick("R4 piece writes");
         end
      end

      // R7/R8: every byte mask, with and without competing writes
      for (int m = 0; m < 16; m++) begin
         for (int k = 0; k < 4; k++) begin
            rand_data();
            word_we = 1; word_bmask = 4'(m);
            if (k[0]) {fp_we, lg_we, ge_we, v_we, c_we, nz_we} = 6'h3F;
            tick(k[0] ? "R8 word priority" : "R7 byte mask");
         end
      end

      // R1: reset mid-run
      rst = 1; tick("R1 mid reset");
      rst = 0; tick("R1 after reset idle");

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule